// File: doc/BRIEF.md
# AUX Request Framer

This block turns one DisplayPort AUX request into the word sequence that a command FIFO and a transaction-control register expect. A request is either native or I2C-over-AUX, either a read or a write. It carries a 20-bit address and a byte length, and writes also bring a payload byte stream. After the handshake the block checks the length. It writes a four-byte header into the command FIFO, then appends the write payload, then issues a single control word that starts the channel. After that it waits for the line side to report completion.

When a read completes, the block pops the reply FIFO. The first entry is thrown away. Each later entry carries a data byte and an 8-bit sequence index. Bytes go out on a plain byte stream until the expected count is reached or an index is out of step. The line side is modelled as a FIFO write port, a FIFO read port and a completion strobe. Every request ends with exactly one response beat that carries a code and a byte count.

Top module: `aux_req_framer`

## Requirements
- R1: After reset, req_ready is 1 and busy, cmd_we, ctrl_we, rx_pop, out_valid and rsp_valid are all 0.
- R2: The four header words come in this order. First {3'b000, read, addr[19:16]}, then addr[15:8], then addr[7:0], then len-1. cmd_idx_rst is 1 on the first header word only.
- R3: A write puts its len payload bytes into the FIFO right after the header. A read writes only the four header words. No request writes more than CMD_FIFO_DEPTH words, and a 124-byte write is accepted as 128 words.
- R4: A request is rejected with rsp_code 2 and rsp_count 0, and with no FIFO word, no control word and no payload byte taken, in three cases: a native request longer than 16 bytes, any request longer than 128 bytes, or a write longer than 124 bytes.
- R5: A zero-length request is answered at once with rsp_code 0 if native or 1 if I2C, and rsp_count 0. It causes no FIFO or control activity.
- R6: Exactly one control word follows the last FIFO word. Bit 0 (go) is always 1. Bit 1 (I2C) and bit 2 (skip address) are 1 for I2C requests. Bit 3 (skip stop) is 1 only for I2C writes. A native request gives 4'b0001, an I2C read gives 4'b0111 and an I2C write gives 4'b1111.
- R7: busy is 1 from the cycle after the control word until completion or timeout. req_ready is 0 whenever a request is in progress. A request held during that time is accepted after the response.
- R8: On a completed read, the first reply entry is popped and dropped. Entries then stream out while their index equals the running count, and the response carries count len.
- R9: If a reply entry has an index that differs from the running count, draining stops. That entry is popped but not emitted. The response gives the ACK code and the count reached so far.
- R10: Without completion, a request ends after TMO_CYCLES busy cycles with rsp_code 3 and rsp_count 0.
- R11: A completion that arrives in the last busy cycle beats the timeout.
- R12: A completed write responds with the ACK code for its type and rsp_count equal to len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Framer idle, request taken |
| req_native | input | 1 | 1 native, 0 I2C-over-AUX |
| req_read | input | 1 | 1 read, 0 write |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Byte count |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| cmd_we | output | 1 | Command FIFO write |
| cmd_byte | output | 8 | Command FIFO data |
| cmd_idx_rst | output | 1 | Resets the FIFO pointer (first word) |
| ctrl_we | output | 1 | Control word write |
| ctrl_word | output | 4 | Control word |
| line_done | input | 1 | Transaction completion strobe |
| busy | output | 1 | Transaction in flight |
| rx_pop | output | 1 | Reply FIFO pop |
| rx_byte | input | 8 | Reply FIFO head data |
| rx_idx | input | LEN_W | Reply FIFO head index |
| out_valid | output | 1 | Read byte out |
| out_byte | output | 8 | Read data |
| rsp_valid | output | 1 | Response beat |
| rsp_code | output | 2 | 0 native ACK, 1 I2C ACK, 2 rejected, 3 timeout |
| rsp_count | output | LEN_W | Bytes transferred |

## Verification
The completion strobe and timeout expiry can fall in the same cycle. The bench provokes this by counting TMO_CYCLES busy cycles after the control word and raising line_done in exactly the last one. It then expects an ACK with the full count, not a timeout, and expects busy to have lasted exactly TMO_CYCLES cycles. A second collision is a new request presented while busy: it must stay unaccepted until the pending response has gone out, and it must then be answered on its own.

// File: rtl/aux_frm_pkg.sv
// Shared encodings for the AUX request framer.
// Assumes: 20-bit AUX address, byte-wide FIFO data.
package aux_frm_pkg;
    localparam int AUX_ADDR_W = 20;
    localparam int BYTE_W     = 8;
    localparam int HDR_WORDS  = 4;
    localparam int CTRL_W     = 4;
    localparam int CTRL_GO      = 0;
    localparam int CTRL_I2C     = 1;
    localparam int CTRL_NO_ADDR = 2;
    localparam int CTRL_NO_STOP = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_PAY, ST_CTRL, ST_WAIT, ST_DISC, ST_DRAIN, ST_RESP
    } frm_state_e;

    typedef enum logic [1:0] {
        RSP_ACK_NATIVE = 2'd0,
        RSP_ACK_I2C    = 2'd1,
        RSP_REJECT     = 2'd2,
        RSP_TIMEOUT    = 2'd3
    } rsp_code_e;
endpackage

// File: rtl/aux_req_check.sv
// Length screening for an incoming request.
// Flags zero-length requests and those that break the native,
// I2C or write-payload limits. Purely combinational.
module aux_req_check #(
    parameter int LEN_W      = 8,
    parameter int NATIVE_MAX = 16,
    parameter int I2C_MAX    = 128,
    parameter int WR_PAY_MAX = 124
) (
    input  logic             native,
    input  logic             read,
    input  logic [LEN_W-1:0] len,
    output logic             zero_len,
    output logic             reject
);
    // Compare the length against each limit.
    always_comb begin
        zero_len = (len == '0);
        reject   = (native && (int'(len) > NATIVE_MAX))
                || (int'(len) > I2C_MAX)
                || (!read && (int'(len) > WR_PAY_MAX));
    end
endmodule

// File: rtl/aux_hdr_pack.sv
// Header byte selection and control word build.
// Assumes len >= 1 whenever the header is used.
module aux_hdr_pack
    import aux_frm_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                  native,
    input  logic                  read,
    input  logic [AUX_ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]      len,
    input  logic [1:0]            hdr_idx,
    output logic [BYTE_W-1:0]     hdr_byte,
    output logic [CTRL_W-1:0]     ctrl_word
);
    logic [LEN_W-1:0] len_m1;

    // Pick the header byte for the current header slot.
    always_comb begin
        len_m1 = len - 1'b1;
        case (hdr_idx)
            2'd0:    hdr_byte = {3'b000, read, addr[19:16]};
            2'd1:    hdr_byte = addr[15:8];
            2'd2:    hdr_byte = addr[7:0];
            default: hdr_byte = len_m1[7:0];
        endcase
    end

    // Build the transaction-control word.
    always_comb begin
        ctrl_word               = '0;
        ctrl_word[CTRL_GO]      = 1'b1;
        ctrl_word[CTRL_I2C]     = !native;
        ctrl_word[CTRL_NO_ADDR] = !native;
        ctrl_word[CTRL_NO_STOP] = !native && !read;
    end
endmodule

// File: rtl/aux_tmo_timer.sv
// Completion watchdog: counts busy cycles and flags the last one.
// Assumes start pulses one cycle before run begins.
module aux_tmo_timer #(
    parameter int TMO_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    // Clear on start, count while running.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // Last permitted busy cycle.
    assign expired = run && (cnt == CNT_W'(TMO_CYCLES - 1));

    // R10: the busy window never outlasts the limit
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < TMO_CYCLES));
endmodule

// File: rtl/aux_req_framer.sv
// AUX request framer: validates a request, writes header and
// payload into the command FIFO, issues the control word, waits for
// completion or timeout, then drains the reply FIFO for reads.
// Assumes the reply FIFO head is valid whenever rx_pop is driven.
module aux_req_framer
    import aux_frm_pkg::*;
#(
    parameter int LEN_W          = 8,
    parameter int NATIVE_MAX     = 16,
    parameter int I2C_MAX        = 128,
    parameter int CMD_BUDGET     = 128,
    parameter int CMD_FIFO_DEPTH = 144,
    parameter int TMO_CYCLES     = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_native,
    input  logic                  req_read,
    input  logic [AUX_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  pl_valid,
    output logic                  pl_ready,
    input  logic [BYTE_W-1:0]     pl_data,
    output logic                  cmd_we,
    output logic [BYTE_W-1:0]     cmd_byte,
    output logic                  cmd_idx_rst,
    output logic                  ctrl_we,
    output logic [CTRL_W-1:0]     ctrl_word,
    input  logic                  line_done,
    output logic                  busy,
    output logic                  rx_pop,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic [LEN_W-1:0]      rx_idx,
    output logic                  out_valid,
    output logic [BYTE_W-1:0]     out_byte,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_code,
    output logic [LEN_W-1:0]      rsp_count
);
    localparam int WR_PAY_MAX = CMD_BUDGET - HDR_WORDS;
    localparam int WORD_W     = $clog2(CMD_FIFO_DEPTH + 1);

    frm_state_e            state;
    logic                  nat_q, rd_q;
    logic [AUX_ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]      len_q, byte_cnt, rx_cnt, count_q;
    logic [1:0]            hdr_idx;
    rsp_code_e             code_q;
    logic [WORD_W-1:0]     words;
    logic                  zero_len, reject, expired, idx_ok;
    logic [BYTE_W-1:0]     hdr_byte;
    rsp_code_e             ack_code;

    aux_req_check #(
        .LEN_W(LEN_W), .NATIVE_MAX(NATIVE_MAX),
        .I2C_MAX(I2C_MAX), .WR_PAY_MAX(WR_PAY_MAX)
    ) u_check (
        .native(req_native), .read(req_read), .len(req_len),
        .zero_len(zero_len), .reject(reject)
    );

    aux_hdr_pack #(.LEN_W(LEN_W)) u_pack (
        .native(nat_q), .read(rd_q), .addr(addr_q), .len(len_q),
        .hdr_idx(hdr_idx), .hdr_byte(hdr_byte), .ctrl_word(ctrl_word)
    );

    aux_tmo_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .start(state == ST_CTRL), .run(state == ST_WAIT),
        .expired(expired)
    );

    assign ack_code = nat_q ? RSP_ACK_NATIVE : RSP_ACK_I2C;
    assign idx_ok   = (rx_idx == rx_cnt);

    // Request sequencing: accept, frame, launch, wait, drain, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            nat_q    <= 1'b0;
            rd_q     <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            hdr_idx  <= '0;
            byte_cnt <= '0;
            rx_cnt   <= '0;
            count_q  <= '0;
            code_q   <= RSP_ACK_NATIVE;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    nat_q   <= req_native;
                    rd_q    <= req_read;
                    addr_q  <= req_addr;
                    len_q   <= req_len;
                    hdr_idx <= '0;
                    count_q <= '0;
                    if (zero_len) begin
                        code_q <= req_native ? RSP_ACK_NATIVE : RSP_ACK_I2C;
                        state  <= ST_RESP;
                    end else if (reject) begin
                        code_q <= RSP_REJECT;
                        state  <= ST_RESP;
                    end else begin
                        state  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    hdr_idx  <= hdr_idx + 1'b1;
                    byte_cnt <= '0;
                    if (hdr_idx == 2'd3) state <= rd_q ? ST_CTRL : ST_PAY;
                end
                ST_PAY: if (pl_valid) begin
                    byte_cnt <= byte_cnt + 1'b1;
                    if (byte_cnt == len_q - 1'b1) state <= ST_CTRL;
                end
                ST_CTRL: state <= ST_WAIT;
                ST_WAIT: begin
                    rx_cnt <= '0;
                    if (line_done) begin
                        if (rd_q) begin
                            state <= ST_DISC;
                        end else begin
                            code_q  <= ack_code;
                            count_q <= len_q;
                            state   <= ST_RESP;
                        end
                    end else if (expired) begin
                        code_q <= RSP_TIMEOUT;
                        state  <= ST_RESP;
                    end
                end
                ST_DISC: state <= ST_DRAIN;
                ST_DRAIN: begin
                    code_q <= ack_code;
                    if (idx_ok) begin
                        rx_cnt <= rx_cnt + 1'b1;
                        if (rx_cnt == len_q - 1'b1) begin
                            count_q <= len_q;
                            state   <= ST_RESP;
                        end
                    end else begin
                        count_q <= rx_cnt;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count FIFO words of the current request (checked below).
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) words <= '0;
        else if (cmd_we)                words <= words + 1'b1;
    end

    // Port strobes decoded from the state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        pl_ready    = (state == ST_PAY);
        cmd_we      = (state == ST_HDR) || ((state == ST_PAY) && pl_valid);
        cmd_byte    = (state == ST_HDR) ? hdr_byte : pl_data;
        cmd_idx_rst = (state == ST_HDR) && (hdr_idx == 2'd0);
        ctrl_we     = (state == ST_CTRL);
        busy        = (state == ST_WAIT);
        rx_pop      = (state == ST_DISC) || (state == ST_DRAIN);
        out_valid   = (state == ST_DRAIN) && idx_ok;
        out_byte    = rx_byte;
        rsp_valid   = (state == ST_RESP);
        rsp_code    = code_q;
        rsp_count   = count_q;
    end

    // R2: pointer reset only on the first word of a request
    a_r2_idx_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_idx_rst |-> (cmd_we && words == '0));
    // R3: never more words than the FIFO holds
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |-> (int'(words) < CMD_FIFO_DEPTH));
    // R7: go is followed by busy; no acceptance while busy
    a_r7_go_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> busy);
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
    // R8: output bytes come only from popped entries
    a_r8_out_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rx_pop);
    // R5: one response beat per request
    a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/aux_req_framer_tb.sv
module aux_req_framer_tb;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        pl_valid = 1'b0, line_done = 1'b0;
    logic        req_ready, pl_ready, cmd_we, cmd_idx_rst, ctrl_we, busy;
    logic        rx_pop, out_valid, rsp_valid;
    logic [7:0]  pl_data, cmd_byte, rx_byte, rx_idx, out_byte, rsp_count;
    logic [3:0]  ctrl_word;
    logic [1:0]  rsp_code;

    aux_req_framer #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_native(req_native), .req_read(req_read), .req_addr(req_addr),
        .req_len(req_len), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .pl_data(pl_data), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .cmd_idx_rst(cmd_idx_rst), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
        .line_done(line_done), .busy(busy), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .rx_idx(rx_idx), .out_valid(out_valid), .out_byte(out_byte),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_count(rsp_count)
    );

    // Line-side models and logs.
    logic [7:0] cmd_log_b [0:1023];
    logic       cmd_log_f [0:1023];
    logic [7:0] out_log   [0:1023];
    logic [7:0] pl_mem    [0:1023];
    logic [7:0] rx_mem_b  [0:1023];
    logic [7:0] rx_mem_i  [0:1023];
    logic [3:0] ctrl_last = '0;
    int cmd_n = 0, ctrl_n = 0, out_n = 0, pl_ptr = 0, rx_head = 0, busy_cyc = 0;
    int tests = 0, fails = 0;

    assign pl_data = pl_mem[pl_ptr];
    assign rx_byte = rx_mem_b[rx_head];
    assign rx_idx  = rx_mem_i[rx_head];

    always @(posedge clk) begin
        if (cmd_we) begin
            cmd_log_b[cmd_n] <= cmd_byte;
            cmd_log_f[cmd_n] <= cmd_idx_rst;
            cmd_n <= cmd_n + 1;
        end
        if (ctrl_we) begin
            ctrl_last <= ctrl_word;
            ctrl_n <= ctrl_n + 1;
        end
        if (out_valid) begin
            out_log[out_n] <= out_byte;
            out_n <= out_n + 1;
        end
        if (pl_ready && pl_valid) pl_ptr <= pl_ptr + 1;
        if (rx_pop) rx_head <= rx_head + 1;
        if (busy) busy_cyc <= busy_cyc + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request. mode 0: done after 3 busy cycles,
    // 1: never done, 2: done in the last busy cycle.
    task automatic issue(input logic nat, input logic rd, input logic [19:0] a,
                         input logic [7:0] l, input int mode,
                         output logic [1:0] code, output logic [7:0] cnt);
        int guard;
        guard = 0;
        @(negedge clk);
        req_native = nat; req_read = rd; req_addr = a; req_len = l;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && !ctrl_we && guard < 1000) begin
            @(negedge clk); guard++;
        end
        if (ctrl_we) begin
            if (mode == 0) begin
                repeat (3) @(negedge clk);
                line_done = 1'b1; @(negedge clk); line_done = 1'b0;
            end else if (mode == 2) begin
                repeat (TMO) @(negedge clk);
                line_done = 1'b1; @(negedge clk); line_done = 1'b0;
            end
            while (!rsp_valid && guard < 2000) begin
                @(negedge clk); guard++;
            end
        end
        code = rsp_code;
        cnt  = rsp_count;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "busy", busy, 0);
        chk("R1", "strobes", {cmd_we, ctrl_we, rx_pop, out_valid, rsp_valid}, 0);
    endtask

    task automatic t_zero();
        logic [1:0] c; logic [7:0] n; int c0, k0;
        c0 = cmd_n; k0 = ctrl_n;
        issue(1'b1, 1'b1, 20'h00100, 8'd0, 0, c, n);
        chk("R5", "native zero code", c, 0);
        chk("R5", "native zero count", n, 0);
        issue(1'b0, 1'b0, 20'h00050, 8'd0, 0, c, n);
        chk("R5", "i2c zero code", c, 1);
        chk("R5", "no fifo/ctrl", (cmd_n - c0) + (ctrl_n - k0), 0);
    endtask

    task automatic t_native_read();
        logic [1:0] c; logic [7:0] n; int c0, k0, o0, h0;
        c0 = cmd_n; k0 = ctrl_n; o0 = out_n; h0 = rx_head;
        rx_mem_b[h0] = 8'hEE; rx_mem_i[h0] = 8'hFF;
        for (int i = 0; i < 16; i++) begin
            rx_mem_b[h0+1+i] = 8'h30 + 8'(i); rx_mem_i[h0+1+i] = 8'(i);
        end
        issue(1'b1, 1'b1, 20'hABCDE, 8'd16, 0, c, n);
        chk("R2", "hdr0", cmd_log_b[c0], 8'h1A);
        chk("R2", "hdr1", cmd_log_b[c0+1], 8'hBC);
        chk("R2", "hdr2", cmd_log_b[c0+2], 8'hDE);
        chk("R2", "hdr3", cmd_log_b[c0+3], 8'h0F);
        chk("R2", "idx_rst flags",
            {cmd_log_f[c0], cmd_log_f[c0+1], cmd_log_f[c0+2], cmd_log_f[c0+3]}, 4'b1000);
        chk("R3", "read word count", cmd_n - c0, 4);
        chk("R6", "native ctrl", {ctrl_n - k0, 28'(ctrl_last)}, {32'd1 << 28} | 32'h1);
        chk("R8", "code", c, 0);
        chk("R8", "count", n, 16);
        chk("R8", "bytes out", out_n - o0, 16);
        chk("R8", "last byte", out_log[o0+15], 8'h3F);
        chk("R8", "pops incl discard", rx_head - h0, 17);
    endtask

    task automatic t_native_write();
        logic [1:0] c; logic [7:0] n; int c0, o0, p0;
        c0 = cmd_n; o0 = out_n; p0 = pl_ptr;
        pl_mem[p0] = 8'hA1; pl_mem[p0+1] = 8'hA2; pl_mem[p0+2] = 8'hA3;
        issue(1'b1, 1'b0, 20'h00123, 8'd3, 0, c, n);
        chk("R2", "write hdr", {cmd_log_b[c0], cmd_log_b[c0+1], cmd_log_b[c0+2], cmd_log_b[c0+3]},
            32'h00012302);
        chk("R3", "payload", {cmd_log_b[c0+4], cmd_log_b[c0+5], cmd_log_b[c0+6]}, 24'hA1A2A3);
        chk("R3", "write word count", cmd_n - c0, 7);
        chk("R6", "native write ctrl", ctrl_last, 4'b0001);
        chk("R12", "write code", c, 0);
        chk("R12", "write count", n, 3);
        chk("R12", "no bytes out", out_n - o0, 0);
    endtask

    task automatic t_i2c_write();
        logic [1:0] c; logic [7:0] n; int p0;
        p0 = pl_ptr; pl_mem[p0] = 8'h20;
        issue(1'b0, 1'b0, 20'h00050, 8'd1, 0, c, n);
        chk("R6", "i2c write ctrl", ctrl_last, 4'b1111);
        chk("R12", "i2c write code/count", {c, n}, {2'd1, 8'd1});
    endtask

    task automatic t_i2c_mismatch();
        logic [1:0] c; logic [7:0] n; int o0, h0;
        o0 = out_n; h0 = rx_head;
        rx_mem_b[h0] = 8'hEE; rx_mem_i[h0] = 8'h00;
        for (int i = 0; i < 8; i++) begin
            rx_mem_b[h0+1+i] = 8'h60 + 8'(i);
            rx_mem_i[h0+1+i] = (i == 5) ? 8'd9 : 8'(i);
        end
        issue(1'b0, 1'b1, 20'h00050, 8'd8, 0, c, n);
        chk("R6", "i2c read ctrl", ctrl_last, 4'b0111);
        chk("R9", "code", c, 1);
        chk("R9", "count", n, 5);
        chk("R9", "bytes out", out_n - o0, 5);
        chk("R9", "pops", rx_head - h0, 7);
    endtask

    task automatic t_limits();
        logic [1:0] c; logic [7:0] n; int c0, k0, p0, h0;
        c0 = cmd_n; k0 = ctrl_n; p0 = pl_ptr;
        issue(1'b1, 1'b1, 20'h00200, 8'd17, 0, c, n);
        chk("R4", "native 17 code", {c, n}, {2'd2, 8'd0});
        issue(1'b0, 1'b1, 20'h00050, 8'd129, 0, c, n);
        chk("R4", "i2c read 129 code", c, 2);
        issue(1'b0, 1'b0, 20'h00050, 8'd125, 0, c, n);
        chk("R4", "write 125 code", c, 2);
        chk("R4", "rejects leave no trace",
            (cmd_n - c0) + (ctrl_n - k0) + (pl_ptr - p0), 0);
        c0 = cmd_n;
        for (int i = 0; i < 124; i++) pl_mem[p0+i] = 8'(i);
        issue(1'b0, 1'b0, 20'h00050, 8'd124, 0, c, n);
        chk("R3", "write 124 words", cmd_n - c0, 128);
        chk("R3", "write 124 last payload", cmd_log_b[c0+127], 8'd123);
        chk("R3", "write 124 code/count", {c, n}, {2'd1, 8'd124});
        c0 = cmd_n; h0 = rx_head;
        rx_mem_i[h0] = 8'hFF;
        for (int i = 0; i < 128; i++) rx_mem_i[h0+1+i] = 8'(i);
        issue(1'b0, 1'b1, 20'h00050, 8'd128, 0, c, n);
        chk("R3", "read 128 words", cmd_n - c0, 4);
        chk("R8", "read 128 code/count", {c, n}, {2'd1, 8'd128});
    endtask

    task automatic t_timeout();
        logic [1:0] c; logic [7:0] n; int b0, o0;
        b0 = busy_cyc; o0 = out_n;
        issue(1'b1, 1'b1, 20'h00300, 8'd2, 1, c, n);
        chk("R10", "timeout code/count", {c, n}, {2'd3, 8'd0});
        chk("R10", "busy cycles", busy_cyc - b0, TMO);
        chk("R10", "no bytes out", out_n - o0, 0);
    endtask

    task automatic t_race();
        logic [1:0] c; logic [7:0] n; int b0, p0;
        b0 = busy_cyc; p0 = pl_ptr; pl_mem[p0] = 8'h55;
        issue(1'b1, 1'b0, 20'h00400, 8'd1, 2, c, n);
        chk("R11", "done at expiry code/count", {c, n}, {2'd0, 8'd1});
        chk("R11", "busy cycles", busy_cyc - b0, TMO);
    endtask

    task automatic t_holdoff();
        int p0;
        p0 = pl_ptr; pl_mem[p0] = 8'h77;
        @(negedge clk);
        req_native = 1'b1; req_read = 1'b0; req_addr = 20'h00500; req_len = 8'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ctrl_we) @(negedge clk);
        @(negedge clk);
        chk("R7", "busy after go", busy, 1);
        req_native = 1'b0; req_read = 1'b1; req_len = 8'd0; req_valid = 1'b1;
        repeat (3) begin
            chk("R7", "ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        line_done = 1'b1; @(negedge clk); line_done = 1'b0;
        chk("R7", "first response", {rsp_valid, rsp_code, rsp_count}, {1'b1, 2'd0, 8'd1});
        @(negedge clk);
        chk("R7", "ready after response", req_ready, 1);
        @(negedge clk);
        chk("R7", "held request answered", {rsp_valid, rsp_code}, {1'b1, 2'd1});
        req_valid = 1'b0;
    endtask

    initial begin
        pl_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_native_read();
        t_native_write();
        t_i2c_write();
        t_i2c_mismatch();
        t_limits();
        t_timeout();
        t_race();
        t_holdoff();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule